// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Status

This block queues characters coming out of a serial receiver. Each stored entry is the data byte together with three error flags: break, framing and parity. Because the flags are stored in the same slot as the byte, the status shown for the oldest character always belongs to that character. When the queue advances, the status advances with it.

A software read of the receive holding register is a `rd_en` pulse, which removes the oldest character. A read of the line status register is an `lsr_rd` pulse, which clears the overrun flag. The block also tracks how many stored characters carry any error. `any_err` stays high until the last of those characters has been read out, so the interrupt logic can raise a line-status interrupt early and keep it up for the whole time erroneous data is queued.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the queue is empty. `data_ready`, `any_err`, `overrun`, `head_data` and the three head flags are all 0.
- R2: An entry is written with `wr_en`, the byte `wr_data` and the flags `wr_brk`, `wr_frm` and `wr_par`. The head outputs show the oldest stored entry, and entries leave in arrival order. Results are visible in the cycle after the write edge.
- R3: `rd_en` on a non-empty queue removes the head entry. From the next cycle, `head_data` and the head flags show the following entry's byte and flags.
- R4: While the queue is empty, `head_brk`, `head_frm`, `head_par` and `head_data` are all 0.
- R5: `any_err` is high exactly when at least one stored entry has a set break, framing or parity flag. It stays high until the last such entry has been read out.
- R6: A write while DEPTH entries are stored is discarded, even if a read happens in the same cycle. The write sets `overrun` and leaves the stored entries unchanged.
- R7: `lsr_rd` clears `overrun` in the next cycle. If a discarded write and `lsr_rd` occur in the same cycle, `overrun` stays set.
- R8: `data_ready` is high exactly when at least one entry is stored. A read and a write in the same cycle on a queue that is neither empty nor full leave the number of entries unchanged.
- R9: `rd_en` on an empty queue has no effect.
- R10: The queue accepts DEPTH = 64 writes in a row with no read, and every one of them is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | DW | Received byte |
| wr_brk | input | 1 | Break flag for the written byte |
| wr_frm | input | 1 | Framing error flag for the written byte |
| wr_par | input | 1 | Parity error flag for the written byte |
| rd_en | input | 1 | Holding register read: remove the head entry |
| lsr_rd | input | 1 | Line status read: clear overrun |
| head_data | output | DW | Byte at the head |
| head_brk | output | 1 | Break flag of the head entry |
| head_frm | output | 1 | Framing flag of the head entry |
| head_par | output | 1 | Parity flag of the head entry |
| data_ready | output | 1 | At least one entry stored |
| any_err | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | A write was lost to a full queue |

## Verification
A pointer or count that is off by one shows up at the ports as the wrong byte, or the wrong flags, on the first read after the fault. A fill to 64 entries followed by a complete drain exposes any such error within one pass. A mistake in the error counter shows up as `any_err` dropping while a flagged character is still queued, or staying high after it has left. Every read of a queue containing one flagged entry checks this in the cycle after the read. Overrun handling shows up on the first write into a full queue.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_brk,
  input  logic          wr_frm,
  input  logic          wr_par,
  input  logic          rd_en,
  input  logic          lsr_rd,
  output logic [DW-1:0] head_data,
  output logic          head_brk,
  output logic          head_frm,
  output logic          head_par,
  output logic          data_ready,
  output logic          any_err,
  output logic          overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, err_cnt;

  wire full    = (count == CW'(DEPTH));
  wire empty   = (count == '0);
  wire do_wr   = wr_en & ~full;
  wire do_rd   = rd_en & ~empty;
  wire wr_err  = wr_brk | wr_frm | wr_par;
  wire [EW-1:0] head = mem[rptr];
  wire head_err = |head[2:0];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= {wr_data, wr_brk, wr_frm, wr_par};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      err_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      count   <= count + CW'(do_wr) - CW'(do_rd);
      err_cnt <= err_cnt + CW'(do_wr & wr_err) - CW'(do_rd & head_err);
      if (wr_en && full) overrun <= 1'b1;
      else if (lsr_rd)   overrun <= 1'b0;
    end
  end

  assign data_ready = ~empty;
  assign any_err    = (err_cnt != '0);
  assign head_data  = empty ? '0 : head[EW-1:3];
  assign head_brk   = ~empty & head[2];
  assign head_frm   = ~empty & head[1];
  assign head_par   = ~empty & head[0];
endmodule

module rx_err_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          lsr_rd,
  input logic [CW-1:0] count,
  input logic [CW-1:0] err_cnt,
  input logic          head_brk,
  input logic          head_frm,
  input logic          head_par,
  input logic          data_ready,
  input logic          any_err,
  input logic          overrun
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !(head_brk | head_frm | head_par));

  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt <= count) && (any_err -> data_ready));

  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_en && count == CW'(DEPTH)));

  // R7
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !(wr_en && count == CW'(DEPTH))) |=> !overrun);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && count != '0 && count != CW'(DEPTH)) |=> $stable(count));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && count == '0) |=> (count == '0));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
  .count(count), .err_cnt(err_cnt), .head_brk(head_brk), .head_frm(head_frm),
  .head_par(head_par), .data_ready(data_ready), .any_err(any_err),
  .overrun(overrun)
);

// File: tb/test_rx_err_fifo.sv
`timescale 1ns/1ps
module test_rx_err_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_brk = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0, lsr_rd = 1'b0;
  logic [7:0] head_data;
  logic       head_brk, head_frm, head_par, data_ready, any_err, overrun;

  rx_err_fifo i_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
    .lsr_rd(lsr_rd), .head_data(head_data), .head_brk(head_brk),
    .head_frm(head_frm), .head_par(head_par), .data_ready(data_ready),
    .any_err(any_err), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  logic [10:0] q[$];
  logic        m_ovr = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic monitor(string req);
    logic [10:0] h;
    logic        e;
    h = (q.size() > 0) ? q[0] : 11'h0;
    e = 1'b0;
    foreach (q[i]) e |= |q[i][2:0];
    chk({req, " head_data"}, head_data, h[10:3]);
    chk({req, " head flags"}, {head_brk, head_frm, head_par}, h[2:0]);
    chk("R8 data_ready", data_ready, q.size() > 0);
    chk("R5 any_err", any_err, e);
    chk("R7 overrun", overrun, m_ovr);
  endtask

  task automatic step(bit w, logic [10:0] v, bit r, bit l, string req);
    bit was_full;
    wr_en = w; {wr_data, wr_brk, wr_frm, wr_par} = v; rd_en = r; lsr_rd = l;
    @(posedge clk);
    was_full = (q.size() == 64);
    if (r && q.size() > 0) void'(q.pop_front());
    if (w && was_full) m_ovr = 1'b1;
    else if (l) m_ovr = 1'b0;
    if (w && !was_full) q.push_back(v);
    @(negedge clk);
    wr_en = 0; rd_en = 0; lsr_rd = 0;
    monitor(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    monitor("R1");
    step(1, {8'hA5, 3'b000}, 0, 0, "R2");
    step(1, {8'h3C, 3'b001}, 0, 0, "R2");
    step(1, {8'h5A, 3'b100}, 0, 0, "R2");
    step(1, {8'h11, 3'b000}, 0, 0, "R2");
    step(0, 11'h0, 1, 0, "R3");
    step(0, 11'h0, 1, 0, "R3");
    step(0, 11'h0, 1, 0, "R5");
    step(0, 11'h0, 1, 0, "R4");
    step(0, 11'h0, 1, 0, "R9");
    step(1, {8'h77, 3'b010}, 0, 0, "R2");
    step(1, {8'h88, 3'b000}, 1, 0, "R8");
    step(0, 11'h0, 1, 0, "R4");
    for (int i = 0; i < 64; i++)
      step(1, {8'(i * 5 + 1), (i % 7 == 3) ? 3'b010 : (i % 11 == 5) ? 3'b101 : 3'b000}, 0, 0, "R10");
    step(1, {8'hFF, 3'b111}, 0, 0, "R6");
    step(1, {8'hEE, 3'b001}, 1, 0, "R6");
    step(0, 11'h0, 0, 1, "R7");
    step(1, {8'h42, 3'b000}, 0, 0, "R2");
    step(1, {8'hDD, 3'b011}, 0, 1, "R7");
    step(0, 11'h0, 0, 1, "R7");
    for (int i = 0; i < 65; i++) step(0, 11'h0, 1, 0, "R3");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule